// File: doc/BRIEF.md
# Secure Memory Partition Access Checker

This block sits in front of a memory and decides, for every access, whether it may proceed. The memory is split in two at a programmable boundary. The lower part, from address zero up to but not including the boundary, belongs to the secure world. Everything at or above the boundary belongs to the nonsecure world. Each request carries an address, a kind (read, write, instruction fetch or configuration write) and the world the requester is running in. One cycle later the block returns a grant or a fault, and a fault comes with a two-bit cause.

The permissions are not symmetric. The nonsecure world cannot touch the secure part in any way. The secure world may read and write the nonsecure part, but it may not fetch instructions from it. Only the secure world may move the boundary. The boundary value is visible at all times on a read-only output. A global enable turns partition checking off. While it is low, every memory access is granted as though the whole memory were nonsecure, and no world counts as secure.

The block also gates the data path. Read data is passed back only for granted reads. A write-commit strobe is raised only for granted writes. A refused access therefore never alters memory and never leaks data.

Top module: `sp_partition_check`

## Requirements
- R1: An address is in the secure region exactly when partition checking is enabled and the address is below the boundary value; a boundary of 0 means no address is secure.
- R2: A read (kind 0), write (kind 1) or fetch (kind 2) from the nonsecure world (world bit 0) to a secure address is refused with cause 1.
- R3: A read, write or fetch from the nonsecure world to a nonsecure address is granted with cause 0.
- R4: The secure world (world bit 1, enable high) is granted reads and writes at any address and fetches from secure addresses, with cause 0.
- R5: A fetch from the secure world to a nonsecure address is refused with cause 2.
- R6: While the enable input is low, every read, write and fetch is granted with cause 0, whatever the world bit and the boundary.
- R7: A configuration write (kind 3) from the secure world with the enable high is granted, and its low ADDR_W data bits become the boundary, seen on the boundary output one cycle later. Any other configuration write is refused with cause 3 and leaves the boundary unchanged.
- R8: Each accepted request produces exactly one response, with the response valid one cycle after the request valid. No response appears in a cycle that follows an idle cycle.
- R9: Response data equals the memory read data for a granted read and is zero for every other response, including refused reads.
- R10: The write-commit strobe is high only in the response to a granted write.
- R11: After reset the response valid and commit strobes are low and the boundary equals its reset parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| part_en | input | 1 | Partition checking enable |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 configuration write |
| req_secure | input | 1 | Requester world, 1 = secure |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Configuration write data |
| mem_rdata | input | DATA_W | Read data from the memory for this request |
| resp_valid | output | 1 | Response strobe |
| resp_grant | output | 1 | Access allowed |
| resp_cause | output | 2 | Fault cause, 0 when granted |
| resp_rdata | output | DATA_W | Gated read data |
| mem_commit | output | 1 | Granted write may update memory |
| cfg_bound | output | ADDR_W | Current boundary value |

## Verification
The decision matrix is driven in every combination of enable, world and kind, at addresses just below and exactly at the boundary. This separates an off-by-one compare from a correct one. A zero boundary and a boundary near the top of the range are both used, so a check that ignores the boundary fails on one of the two. Configuration writes are issued from both worlds and with checking disabled, and the boundary output is read after each one, so an illegal write that slips through shows up. Seeded random requests with random read data then mix all of these cases, which exposes mistakes in data gating and commit gating that directed cases alone could miss.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_FETCH = 2'd2,
    K_CFG   = 2'd3
  } acc_kind_t;

  typedef enum logic [1:0] {
    C_NONE         = 2'd0,
    C_NS_TO_SEC    = 2'd1,
    C_SEC_FETCH_NS = 2'd2,
    C_BAD_CFG      = 2'd3
  } cause_t;

  typedef struct packed {
    logic   grant;
    cause_t cause;
  } verdict_t;
endpackage

// File: rtl/sp_bound_reg.sv
module sp_bound_reg #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BOUND_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] bound
);
  logic [ADDR_W-1:0] bound_nxt;

  always_comb begin
    bound_nxt = bound;
    if (wr_en) bound_nxt = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bound <= BOUND_RST;
    else        bound <= bound_nxt;
  end
endmodule

// File: rtl/sp_perm.sv
module sp_perm
  import sp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              part_en,
  input  logic              world_sec,
  input  acc_kind_t         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] bound,
  output verdict_t          verdict,
  output logic              cfg_ok
);
  logic eff_sec;
  logic in_sec;

  assign eff_sec = world_sec & part_en;
  assign in_sec  = part_en & (addr < bound);
  assign cfg_ok  = (kind == K_CFG) & eff_sec;

  always_comb begin
    verdict = '{grant: 1'b1, cause: C_NONE};
    if (kind == K_CFG) begin
      if (!eff_sec) verdict = '{grant: 1'b0, cause: C_BAD_CFG};
    end else if (in_sec && !eff_sec) begin
      verdict = '{grant: 1'b0, cause: C_NS_TO_SEC};
    end else if (!in_sec && eff_sec && kind == K_FETCH) begin
      verdict = '{grant: 1'b0, cause: C_SEC_FETCH_NS};
    end
  end
endmodule

// File: rtl/sp_resp.sv
module sp_resp
  import sp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  acc_kind_t         kind,
  input  verdict_t          verdict,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [1:0]        resp_cause,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_commit
);
  logic              valid_nxt, grant_nxt, commit_nxt;
  logic [1:0]        cause_nxt;
  logic [DATA_W-1:0] rdata_nxt;
  logic              data_en;

  assign data_en = req_valid | resp_valid;

  always_comb begin
    valid_nxt  = req_valid;
    grant_nxt  = req_valid & verdict.grant;
    cause_nxt  = req_valid ? verdict.cause : C_NONE;
    commit_nxt = grant_nxt & (kind == K_WRITE);
    rdata_nxt  = (grant_nxt && kind == K_READ) ? mem_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
      resp_cause <= 2'd0;
      mem_commit <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= valid_nxt;
      resp_grant <= grant_nxt;
      resp_cause <= cause_nxt;
      mem_commit <= commit_nxt;
      if (data_en) resp_rdata <= rdata_nxt;
    end
  end
endmodule

// File: rtl/sp_partition_check.sv
module sp_partition_check
  import sp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BOUND_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              part_en,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [1:0]        resp_cause,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_commit,
  output logic [ADDR_W-1:0] cfg_bound
);
  localparam int CFG_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

  acc_kind_t         kind;
  verdict_t          verdict;
  logic              cfg_ok;
  logic [ADDR_W-1:0] cfg_data;

  assign kind = acc_kind_t'(req_kind);

  always_comb begin
    cfg_data = '0;
    cfg_data[CFG_W-1:0] = req_wdata[CFG_W-1:0];
  end

  sp_perm #(.ADDR_W(ADDR_W)) u_perm (
    .part_en  (part_en),
    .world_sec(req_secure),
    .kind     (kind),
    .addr     (req_addr),
    .bound    (cfg_bound),
    .verdict  (verdict),
    .cfg_ok   (cfg_ok)
  );

  sp_bound_reg #(.ADDR_W(ADDR_W), .BOUND_RST(BOUND_RST)) u_bound (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (req_valid & cfg_ok),
    .wr_data(cfg_data),
    .bound  (cfg_bound)
  );

  sp_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .kind      (kind),
    .verdict   (verdict),
    .mem_rdata (mem_rdata),
    .resp_valid(resp_valid),
    .resp_grant(resp_grant),
    .resp_cause(resp_cause),
    .resp_rdata(resp_rdata),
    .mem_commit(mem_commit)
  );
endmodule

// File: rtl/sp_partition_check_sva.sv
module sp_partition_check_sva #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              part_en,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              req_secure,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic              resp_grant,
  input logic [1:0]        resp_cause,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              mem_commit,
  input logic [ADDR_W-1:0] cfg_bound
);
  assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_no_idle_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  assert_cause_matches_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_grant == (resp_cause == 2'd0)));
  assert_refused_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_grant) |-> (resp_rdata == '0));
  assert_commit_needs_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit |-> (resp_valid && resp_grant));
  assert_bound_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_kind == 2'd3 && req_secure && part_en) |=> $stable(cfg_bound));
  assert_disabled_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !part_en && req_kind != 2'd3) |=> resp_grant);
  assert_sec_fetch_ns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && part_en && req_secure && req_kind == 2'd2 && req_addr >= cfg_bound)
      |=> (resp_cause == 2'd2));
endmodule

bind sp_partition_check sp_partition_check_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .part_en   (part_en),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_secure(req_secure),
  .req_addr  (req_addr),
  .resp_valid(resp_valid),
  .resp_grant(resp_grant),
  .resp_cause(resp_cause),
  .resp_rdata(resp_rdata),
  .mem_commit(mem_commit),
  .cfg_bound (cfg_bound)
);

// File: tb/sp_partition_check_test.sv
`timescale 1ns/1ps
module sp_partition_check_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          part_en;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic          req_secure;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] mem_rdata;
  logic          resp_valid, resp_grant, mem_commit;
  logic [1:0]    resp_cause;
  logic [DW-1:0] resp_rdata;
  logic [AW-1:0] cfg_bound;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] bound_m;

  always #2 clk = ~clk;

  sp_partition_check #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .part_en(part_en), .req_valid(req_valid),
    .req_kind(req_kind), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .resp_cause(resp_cause), .resp_rdata(resp_rdata),
    .mem_commit(mem_commit), .cfg_bound(cfg_bound)
  );

  function automatic logic [1:0] exp_cause(input logic en, input logic w,
                                           input logic [1:0] k, input logic [AW-1:0] a,
                                           input logic [AW-1:0] b);
    logic s, in_s;
    s    = w & en;
    in_s = en & (a < b);
    if (k == 2'd3) return s ? 2'd0 : 2'd3;
    if (in_s && !s) return 2'd1;
    if (!in_s && s && k == 2'd2) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request, wait for its response and check every output
  task automatic access(input string req, input logic en, input logic w,
                        input logic [1:0] k, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd);
    logic [1:0]    c;
    logic [DW-1:0] rd;
    rd = $urandom;
    c  = exp_cause(en, w, k, a, bound_m);
    part_en = en; req_valid = 1'b1; req_secure = w; req_kind = k;
    req_addr = a; req_wdata = wd; mem_rdata = rd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (k == 2'd3 && c == 2'd0) bound_m = wd[AW-1:0];
    check({req, " valid R8"}, 64'(resp_valid), 64'd1);
    check({req, " cause"}, 64'(resp_cause), 64'(c));
    check({req, " grant"}, 64'(resp_grant), 64'(c == 2'd0));
    check({req, " data R9"}, 64'(resp_rdata), (k == 2'd0 && c == 2'd0) ? 64'(rd) : 64'd0);
    check({req, " commit R10"}, 64'(mem_commit), 64'(k == 2'd1 && c == 2'd0));
    check({req, " bound R7"}, 64'(cfg_bound), 64'(bound_m));
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; part_en = 1'b1; req_valid = 1'b0; req_kind = 2'd0;
    req_secure = 1'b0; req_addr = '0; req_wdata = '0; mem_rdata = '0;
    bound_m = '0;
    repeat (3) @(posedge clk);
    #1;
    check("reset valid R11", 64'(resp_valid), 64'd0);
    check("reset commit R11", 64'(mem_commit), 64'd0);
    check("reset bound R11", 64'(cfg_bound), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("idle no response R8", 64'(resp_valid), 64'd0);

    // boundary 0: no secure region (R1)
    access("R1 zero bound ns fetch", 1'b1, 1'b0, 2'd2, 16'h0000, '0);
    access("R1 zero bound sec fetch", 1'b1, 1'b1, 2'd2, 16'h0000, '0);
    // illegal config writes
    access("R7 ns cfg write", 1'b1, 1'b0, 2'd3, '0, 32'h1000);
    access("R7 disabled cfg write", 1'b0, 1'b1, 2'd3, '0, 32'h1000);
    access("R7 legal cfg write", 1'b1, 1'b1, 2'd3, '0, 32'h1000);
    // edge of region
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 3; k++) begin
        access("R2 R4 below bound", 1'b1, w[0], k[1:0], 16'h0FFF, '0);
        access("R3 R5 at bound", 1'b1, w[0], k[1:0], 16'h1000, '0);
        access("R6 disabled below bound", 1'b0, w[0], k[1:0], 16'h0FFF, '0);
      end
    access("R2 ns read addr 0", 1'b1, 1'b0, 2'd0, 16'h0000, '0);
    access("R5 sec fetch top", 1'b1, 1'b1, 2'd2, 16'hFFFF, '0);
    access("R7 high bound", 1'b1, 1'b1, 2'd3, '0, 32'hABCD_FFFF);
    access("R4 sec fetch below top", 1'b1, 1'b1, 2'd2, 16'hFFFE, '0);
    access("R2 ns write below top", 1'b1, 1'b0, 2'd1, 16'hFFFE, '0);
    access("R3 ns read top", 1'b1, 1'b0, 2'd0, 16'hFFFF, '0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]    k;
      logic [AW-1:0] a;
      logic [DW-1:0] wd;
      k  = 2'($urandom_range(0, 3));
      a  = ($urandom_range(0, 3) == 0) ? bound_m - 16'($urandom_range(0, 1)) : AW'($urandom);
      wd = ($urandom_range(0, 1) == 0) ? DW'($urandom_range(0, 16'h2000)) : DW'($urandom);
      access("R1 R2 R3 R4 R5 R6 R7 random", ($urandom_range(0, 7) != 0),
             1'($urandom), k, a, wd);
      if ($urandom_range(0, 4) == 0) begin
        @(posedge clk); #1;
        check("R8 idle gap", 64'(resp_valid), 64'd0);
        check("R10 idle no commit", 64'(mem_commit), 64'd0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule